// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This unit connects a UART's receive and transmit paths to the modem handshake pins. On the transmit side, it decides whether the transmitter may start another character. When automatic clear-to-send handling is on, a high (inactive) level on the CTS input stops transmission. The stop only takes effect at a character boundary, so a character that is already being shifted out always completes.

On the receive side, it drives the RTS pin from the receive FIFO occupancy. RTS goes high (inactive) once the fill level reaches a halt threshold. It goes low (active) again only after the level has drained to a lower restore threshold, which gives hysteresis. When automatic RTS is off, the pin simply follows a level chosen by software.

A third path watches every received byte and compares it with a programmable XOFF2 character. On a match it raises a sticky special-character flag that software clears. The byte itself still goes to the FIFO, because this unit only observes the receive stream.

The block is built from three small state machines:

- **Transmit gate:** states `TX_GO` and `TX_HOLD`.
  - `GO_TO_HOLD` is taken at a character boundary when auto-CTS is on and CTS is high.
  - `HOLD_TO_GO` is taken whenever CTS is low or auto-CTS is off.
- **RTS controller:** states `RTS_ASSERT` and `RTS_HALT`.
  - `ASSERT_TO_HALT` is taken when the level reaches the halt count.
  - `HALT_TO_ASSERT` is taken when the restore condition is met or auto-RTS is off.
- **Character matcher:** states `FLAG_CLEAR` and `FLAG_RAISED`.
  - `CLEAR_TO_RAISED` is taken on a match.
  - `RAISED_TO_CLEAR` is taken on a software clear when no match arrives in the same cycle.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While auto_cts_en is 0, tx_permit is 1 from the cycle after the clock edge, whatever the cts_pin and tx_boundary inputs do.
- R2: With auto_cts_en at 1, if cts_pin is 1 and tx_boundary is 1 at a clock edge, tx_permit is 0 after that edge.
- R3: tx_permit falls only after an edge at which tx_boundary was 1, so a CTS deassertion in the middle of a character has no effect until the next boundary.
- R4: While transmission is held, an edge with cts_pin at 0 makes tx_permit 1 after that edge.
- R5: With auto_rts_en at 1, an edge at which rx_level is at least halt_thr×THR_SCALE makes rts_pin 1 (inactive) after that edge.
- R6: With auto_rts_en at 1 and restore_thr below halt_thr, a halted RTS returns to 0 after an edge at which rx_level is at most restore_thr×THR_SCALE.
- R7: While halted with restore_thr below halt_thr, rts_pin stays 1 for every level above restore_thr×THR_SCALE, including levels below the halt count.
- R8: When restore_thr is greater than or equal to halt_thr, a halted RTS returns to 0 after the first edge at which rx_level is below halt_thr×THR_SCALE.
- R9: While auto_rts_en is 0, rts_pin equals sw_rts_level regardless of rx_level.
- R10: With spec_det_en at 1, an edge with rx_strobe at 1 and rx_data equal to xoff2_val sets spec_flag after that edge. A simultaneous spec_clr loses to the new match.
- R11: spec_flag stays 1 until spec_clr is pulsed.
- R12: An edge with spec_clr at 1 and no new match returns spec_flag to 0.
- R13: A received byte that differs from xoff2_val, or any byte while spec_det_en is 0, leaves spec_flag at 0.
- R14: After reset, tx_permit is 1, spec_flag is 0 and the RTS controller is in its asserted state, so with auto_rts_en on at an empty FIFO rts_pin is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_cts_en | input | 1 | Enable CTS gating of transmission |
| auto_rts_en | input | 1 | Enable FIFO-driven RTS |
| spec_det_en | input | 1 | Enable special-character compare |
| halt_thr | input | THR_W | Halt threshold, in units of THR_SCALE entries |
| restore_thr | input | THR_W | Restore threshold, in units of THR_SCALE entries |
| xoff2_val | input | DATA_W | Character to match |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_strobe | input | 1 | A received byte is valid this cycle |
| rx_data | input | DATA_W | Received byte |
| cts_pin | input | 1 | CTS pin, 1 = inactive |
| tx_boundary | input | 1 | Transmitter is between characters |
| sw_rts_level | input | 1 | Pin level used when auto-RTS is off |
| spec_clr | input | 1 | Software clear of the special-character flag |
| rts_pin | output | 1 | RTS pin, 1 = inactive |
| tx_permit | output | 1 | Transmitter may start a character |
| spec_flag | output | 1 | Sticky special-character flag |

## Verification
The bench builds the block with its default parameters: THR_SCALE of 4 and a 7-bit level. Every threshold code from 0 to 15 therefore maps to a reachable count of up to 60 entries.

The fill-and-drain test uses a halt count of 40 and a restore count of 16. It walks the level up through every value to the halt count and back down, so both edges of the hysteresis band are crossed one entry at a time. A second pair of thresholds, with restore above halt, reaches the collapsed-band rule.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic {TX_GO, TX_HOLD} tx_state_e;
    typedef enum logic {RTS_ASSERT, RTS_HALT} rts_state_e;
    typedef enum logic {FLAG_CLEAR, FLAG_RAISED} flag_state_e;
endpackage

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cts_pin,
    input  logic tx_boundary,
    output logic tx_permit
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_GO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_GO:   if (enable && cts_pin && tx_boundary) state_d = TX_HOLD;  // GO_TO_HOLD
            TX_HOLD: if (!enable || !cts_pin)              state_d = TX_GO;    // HOLD_TO_GO
            default: state_d = TX_GO;
        endcase
    end

    always_comb tx_permit = (state_q == TX_GO);

    AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> tx_permit); // R1
    AST_CTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cts_pin && tx_boundary) |=> !tx_permit); // R2
    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_permit) |-> $past(tx_boundary)); // R3
    AST_CTS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_permit && !cts_pin) |=> tx_permit); // R4
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
    import fc_pkg::*;
#(
    parameter int THR_W     = 4,
    parameter int LVL_W     = 7,
    parameter int THR_SCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [THR_W-1:0] halt_thr,
    input  logic [THR_W-1:0] restore_thr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             sw_rts_level,
    output logic             rts_pin
);
    rts_state_e       state_q, state_d;
    logic [LVL_W-1:0] halt_cnt, restore_cnt;
    logic             band_ok, release_ok;

    always_comb begin
        halt_cnt    = LVL_W'(halt_thr) * LVL_W'(THR_SCALE);
        restore_cnt = LVL_W'(restore_thr) * LVL_W'(THR_SCALE);
        band_ok     = (restore_thr < halt_thr);
        release_ok  = band_ok ? (rx_level <= restore_cnt) : (rx_level < halt_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_ASSERT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_ASSERT: if (enable && rx_level >= halt_cnt) state_d = RTS_HALT;   // ASSERT_TO_HALT
            RTS_HALT:   if (!enable || release_ok)          state_d = RTS_ASSERT; // HALT_TO_ASSERT
            default:    state_d = RTS_ASSERT;
        endcase
    end

    always_comb rts_pin = enable ? (state_q == RTS_HALT) : sw_rts_level;

    AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rx_level >= halt_cnt) |=> (!enable || rts_pin)); // R5
    AST_RTS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rts_pin && band_ok && rx_level <= restore_cnt) |=> (!enable || !rts_pin)); // R6
    AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rts_pin && band_ok && rx_level > restore_cnt) |=> (!enable || rts_pin)); // R7
    AST_RTS_COLLAPSED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rts_pin && !band_ok && rx_level < halt_cnt) |=> (!enable || !rts_pin)); // R8
endmodule

// File: rtl/fc_char_match.sv
module fc_char_match
    import fc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DATA_W-1:0] xoff2_val,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              spec_clr,
    output logic              spec_flag
);
    flag_state_e state_q, state_d;
    logic        hit;

    always_comb hit = enable && rx_strobe && (rx_data == xoff2_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (hit)              state_d = FLAG_RAISED; // CLEAR_TO_RAISED
            FLAG_RAISED: if (spec_clr && !hit) state_d = FLAG_CLEAR;  // RAISED_TO_CLEAR
            default:     state_d = FLAG_CLEAR;
        endcase
    end

    always_comb spec_flag = (state_q == FLAG_RAISED);

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> spec_flag); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_flag && !spec_clr) |=> spec_flag); // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_clr && !(enable && rx_strobe && rx_data == xoff2_val)) |=> !spec_flag); // R12
    AST_NO_FALSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_flag && !(enable && rx_strobe && rx_data == xoff2_val)) |=> !spec_flag); // R13
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int DATA_W    = 8,
    parameter int THR_W     = 4,
    parameter int THR_SCALE = 4,
    parameter int LVL_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_cts_en,
    input  logic              auto_rts_en,
    input  logic              spec_det_en,
    input  logic [THR_W-1:0]  halt_thr,
    input  logic [THR_W-1:0]  restore_thr,
    input  logic [DATA_W-1:0] xoff2_val,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              cts_pin,
    input  logic              tx_boundary,
    input  logic              sw_rts_level,
    input  logic              spec_clr,
    output logic              rts_pin,
    output logic              tx_permit,
    output logic              spec_flag
);
    fc_tx_gate u_tx_gate (
        .clk(clk), .rst_n(rst_n), .enable(auto_cts_en), .cts_pin(cts_pin),
        .tx_boundary(tx_boundary), .tx_permit(tx_permit)
    );

    fc_rts_ctrl #(.THR_W(THR_W), .LVL_W(LVL_W), .THR_SCALE(THR_SCALE)) u_rts_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(auto_rts_en), .halt_thr(halt_thr),
        .restore_thr(restore_thr), .rx_level(rx_level), .sw_rts_level(sw_rts_level),
        .rts_pin(rts_pin)
    );

    fc_char_match #(.DATA_W(DATA_W)) u_char_match (
        .clk(clk), .rst_n(rst_n), .enable(spec_det_en), .xoff2_val(xoff2_val),
        .rx_strobe(rx_strobe), .rx_data(rx_data), .spec_clr(spec_clr),
        .spec_flag(spec_flag)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (tx_permit && !spec_flag)); // R14
endmodule

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_cts_en = 0, auto_rts_en = 0, spec_det_en = 0;
    logic [3:0] halt_thr = 0, restore_thr = 0;
    logic [7:0] xoff2_val = 0, rx_data = 0;
    logic [6:0] rx_level = 0;
    logic       rx_strobe = 0, cts_pin = 0, tx_boundary = 0, sw_rts_level = 0, spec_clr = 0;
    logic       rts_pin, tx_permit, spec_flag;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .spec_det_en(spec_det_en), .halt_thr(halt_thr), .restore_thr(restore_thr),
        .xoff2_val(xoff2_val), .rx_level(rx_level), .rx_strobe(rx_strobe), .rx_data(rx_data),
        .cts_pin(cts_pin), .tx_boundary(tx_boundary), .sw_rts_level(sw_rts_level),
        .spec_clr(spec_clr), .rts_pin(rts_pin), .tx_permit(tx_permit), .spec_flag(spec_flag)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R14 permit after reset", tx_permit, 1'b1);
        chk("R14 flag after reset", spec_flag, 1'b0);
        auto_rts_en = 1; rx_level = 0;
        #1 chk("R14 rts asserted after reset", rts_pin, 1'b0);
        auto_rts_en = 0;
    endtask

    task automatic t_cts();
        auto_cts_en = 0; cts_pin = 1; tx_boundary = 1;
        step(); step();
        chk("R1 cts ignored when disabled", tx_permit, 1'b1);
        auto_cts_en = 1; tx_boundary = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 no stop mid character", tx_permit, 1'b1);
        end
        tx_boundary = 1;
        step();
        chk("R2 stop at boundary", tx_permit, 1'b0);
        cts_pin = 0;
        step();
        chk("R4 resume on cts low", tx_permit, 1'b1);
        cts_pin = 1;
        step();
        chk("R2 stop again", tx_permit, 1'b0);
        auto_cts_en = 0;
        step();
        chk("R1 disable releases hold", tx_permit, 1'b1);
        cts_pin = 0; tx_boundary = 0;
    endtask

    task automatic t_rts_band();
        auto_rts_en = 1; halt_thr = 4'd10; restore_thr = 4'd4;
        for (int l = 0; l < 40; l++) begin
            rx_level = 7'(l); step();
            chk("R5 below halt stays active", rts_pin, 1'b0);
        end
        rx_level = 7'd40; step();
        chk("R5 halt at threshold", rts_pin, 1'b1);
        for (int l = 39; l > 16; l--) begin
            rx_level = 7'(l); step();
            chk("R7 hysteresis hold", rts_pin, 1'b1);
        end
        rx_level = 7'd16; step();
        chk("R6 restore at threshold", rts_pin, 1'b0);
        rx_level = 7'd30; step();
        chk("R6 stays active inside band", rts_pin, 1'b0);
    endtask

    task automatic t_rts_collapsed();
        halt_thr = 4'd5; restore_thr = 4'd9;
        rx_level = 7'd20; step();
        chk("R8 halt at 20", rts_pin, 1'b1);
        step();
        chk("R8 held at 20", rts_pin, 1'b1);
        rx_level = 7'd19; step();
        chk("R8 release below halt", rts_pin, 1'b0);
    endtask

    task automatic t_rts_sw();
        auto_rts_en = 0; sw_rts_level = 1; rx_level = 0; step();
        chk("R9 software high", rts_pin, 1'b1);
        sw_rts_level = 0; rx_level = 7'd60; step();
        chk("R9 software low at full level", rts_pin, 1'b0);
        rx_level = 0;
    endtask

    task automatic t_spec();
        spec_det_en = 1; xoff2_val = 8'h13;
        rx_strobe = 1; rx_data = 8'h11; step();
        chk("R13 mismatch no flag", spec_flag, 1'b0);
        rx_data = 8'h13; step();
        chk("R10 match sets flag", spec_flag, 1'b1);
        rx_strobe = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R11 flag sticky", spec_flag, 1'b1);
        end
        spec_clr = 1; step();
        chk("R12 clear", spec_flag, 1'b0);
        rx_strobe = 1; step();
        chk("R10 match wins over clear", spec_flag, 1'b1);
        rx_strobe = 0; step();
        chk("R12 clear after win", spec_flag, 1'b0);
        spec_clr = 0; spec_det_en = 0; rx_strobe = 1; step();
        chk("R13 disabled no flag", spec_flag, 1'b0);
        rx_strobe = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        #25 rst_n = 1;
        #2;
        t_reset();
        t_cts();
        t_rts_band();
        t_rts_collapsed();
        t_rts_sw();
        t_spec();
        done = 1;
        summary();
    end
endmodule